// File: doc/BRIEF.md
# Infrared Biphase Remote-Control Frame Decoder

This block turns the demodulated output of an infrared receiver into decoded remote-control frames. The receiver line is active low, so it rests high between frames. Each frame is Manchester coded. The decoder does not need the bit rate in advance. It waits for the line to stay quiet, then times the low part of the first start pulse and takes that width as half a bit period. From that width it derives two limits, one at three quarters of a bit and one at five quarters. It checks the second start bit, then samples twelve data bits. After every bit it re-aligns its timer on the edge in the middle of that bit.

All timing is counted in ticks from a built-in prescaler that divides the system clock. A finished frame is reported as a toggle bit, a 5-bit address and a 6-bit command, together with a one-cycle valid strobe. Any failed attempt is reported with a one-cycle error strobe, and all of its fields read as ones. The result outputs have no ready input and no back-pressure. A consumer has to take the strobe in the cycle it appears. The field outputs keep their values until the next strobe.

Top module: `ir_biphase_rx`

## Requirements
- R1: After reset both strobes are low and the toggle, address and command outputs are zero.
- R2: A tick lasts one clock cycle and comes once every TICK_DIV clock cycles. Every duration below is counted in ticks.
- R3: A start pulse is only looked for once the line has stayed high for IDLE_TICKS (55) ticks without a break. A frame whose start comes after a shorter quiet stretch yields no strobe at all.
- R4: If no start pulse has begun within FRAME_TO (2048) ticks of the attempt beginning, an error strobe is raised. This includes the case of a line held low.
- R5: A low start pulse of HALF_MAX (17) ticks or longer produces an error. A measured width h from 4 to 16 ticks is accepted as half a bit.
- R6: After the start pulse rises, the line must fall again before h + h/2 ticks have passed, otherwise an error is raised.
- R7: Twelve bits are received MSB first. Each bit is sampled h + h/2 ticks after the last mid-bit edge, and a high line reads as 1. The first bit goes to the toggle output, the next five to the address (first received in bit 4) and the last six to the command (first received in bit 5).
- R8: After a 1 is sampled, a falling edge must follow, and after a 0 a rising edge, both before h/2 + 2h ticks. A missing edge produces an error.
- R9: An error strobe is one cycle long, never coincides with the valid strobe, and comes with the address at 5'h1F, the command at 6'h3F and the toggle at 1.
- R10: The valid strobe is one cycle long and rises three clock edges after the line changes at the final mid-bit edge. The fields change only together with a strobe.
- R11: Decoding works for any half-bit width from 4 to 16 ticks, because the limits are taken from the measured start pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_n | input | 1 | Demodulated receiver line, idle high |
| frame_valid | output | 1 | One-cycle strobe for a decoded frame |
| frame_error | output | 1 | One-cycle strobe for a failed attempt |
| frame_toggle | output | 1 | Toggle bit of the last result |
| frame_addr | output | 5 | Address field of the last result |
| frame_cmd | output | 6 | Command field of the last result |

## Verification
The line input passes through two synchroniser flops and one edge register before the state machine, which registers its strobes. The valid strobe is therefore due exactly three clock edges after the bench drives the final mid-bit edge. The bench samples it half a cycle after that third edge, and checks one cycle later that it has dropped. Error strobes depend on when the free-running tick falls, so the bench searches for them inside a window of a few ticks around the limit it computes. The frame timeout is due about FRAME_TO times TICK_DIV cycles after reset is released.

// File: rtl/ir_rx_pkg.sv
`timescale 1ns/1ps
package ir_rx_pkg;
  localparam int IR_ADDR_W = 5;
  localparam int IR_CMD_W  = 6;

  typedef enum logic [2:0] {
    ST_QUIET,   // waiting for an unbroken high stretch
    ST_ARMED,   // quiet seen, waiting for start pulse
    ST_MEASURE, // timing the first low start pulse
    ST_GAP,     // waiting for the second start bit to fall
    ST_SAMPLE,  // waiting for the sample point
    ST_ALIGN    // waiting for the mid-bit edge
  } rx_state_e;
endpackage

// File: rtl/ir_tick_gen.sv
`timescale 1ns/1ps
module ir_tick_gen #(
  parameter int DIV = 3200
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int W = $clog2(DIV);
      localparam logic [W-1:0] LAST = W'(DIV - 1);
      logic [W-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              div_q <= '0;
        else if (div_q == LAST)  div_q <= '0;
        else                     div_q <= div_q + 1'b1;
      end
      assign tick = (div_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/ir_line_sync.sv
`timescale 1ns/1ps
module ir_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic level,
  output logic rise,
  output logic fall
);
  logic meta_q, stab_q, prev_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      stab_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= line_in;
      stab_q <= meta_q;
      prev_q <= stab_q;
    end
  end
  assign level = stab_q;
  assign rise  = stab_q & ~prev_q;
  assign fall  = ~stab_q & prev_q;
endmodule

// File: rtl/ir_frame_fsm.sv
`timescale 1ns/1ps
module ir_frame_fsm
  import ir_rx_pkg::*;
#(
  parameter int IDLE_TICKS = 55,
  parameter int HALF_MAX   = 17,
  parameter int FRAME_TO   = 2048,
  parameter int CNT_W      = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 level,
  input  logic                 rise,
  input  logic                 fall,
  output logic                 out_valid,
  output logic                 out_error,
  output logic                 out_toggle,
  output logic [IR_ADDR_W-1:0] out_addr,
  output logic [IR_CMD_W-1:0]  out_cmd
);
  localparam int NBITS  = 1 + IR_ADDR_W + IR_CMD_W;
  localparam int LCNT_W = $clog2(FRAME_TO + 1);
  localparam int BC_W   = $clog2(NBITS + 1);
  localparam int REF_W  = CNT_W + 2;
  localparam logic [CNT_W-1:0]  IDLE_LIM  = CNT_W'(IDLE_TICKS);
  localparam logic [CNT_W-1:0]  HALF_LIM  = CNT_W'(HALF_MAX);
  localparam logic [LCNT_W-1:0] FRAME_LIM = LCNT_W'(FRAME_TO);

  rx_state_e          st_q, st_d;
  logic [CNT_W-1:0]   ivl_q;
  logic [LCNT_W-1:0]  lng_q;
  logic [REF_W-1:0]   ref_samp_q, ref_edge_q, ivl_x, half_x;
  logic [NBITS-1:0]   sr_q;
  logic [BC_W-1:0]    left_q;
  logic ivl_clr, cap, arm, shift, step, fin_ok, fin_err, long_out;

  assign ivl_x    = {2'b00, ivl_q};
  assign half_x   = ivl_x >> 1;
  assign long_out = (lng_q >= FRAME_LIM);

  always_comb begin
    st_d = st_q; ivl_clr = 1'b0; cap = 1'b0; arm = 1'b0;
    shift = 1'b0; step = 1'b0; fin_ok = 1'b0; fin_err = 1'b0;
    unique case (st_q)
      ST_QUIET: begin
        if (long_out)              fin_err = 1'b1;
        else if (ivl_q >= IDLE_LIM) st_d = ST_ARMED;
        else if (!level)           ivl_clr = 1'b1;
      end
      ST_ARMED: begin
        if (long_out) fin_err = 1'b1;
        else if (!level) begin ivl_clr = 1'b1; st_d = ST_MEASURE; end
      end
      ST_MEASURE: begin
        if (ivl_q >= HALF_LIM) fin_err = 1'b1;
        else if (rise) begin cap = 1'b1; ivl_clr = 1'b1; st_d = ST_GAP; end
      end
      ST_GAP: begin
        if (ivl_x >= ref_samp_q) fin_err = 1'b1;
        else if (fall) begin ivl_clr = 1'b1; arm = 1'b1; st_d = ST_SAMPLE; end
      end
      ST_SAMPLE: begin
        if (ivl_x >= ref_samp_q) begin shift = 1'b1; st_d = ST_ALIGN; end
      end
      ST_ALIGN: begin
        if (ivl_x >= ref_edge_q) fin_err = 1'b1;
        else if (sr_q[0] ? fall : rise) begin
          ivl_clr = 1'b1; step = 1'b1;
          if (left_q == BC_W'(1)) fin_ok = 1'b1;
          else                    st_d = ST_SAMPLE;
        end
      end
      default: st_d = ST_QUIET;
    endcase
    if (fin_ok || fin_err) begin
      st_d = ST_QUIET; ivl_clr = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_QUIET; ivl_q <= '0; lng_q <= '0;
      ref_samp_q <= '0; ref_edge_q <= '0; sr_q <= '0; left_q <= '0;
      out_valid <= 1'b0; out_error <= 1'b0; out_toggle <= 1'b0;
      out_addr <= '0; out_cmd <= '0;
    end else begin
      st_q <= st_d;
      // a clear still counts a tick in the same cycle
      if (ivl_clr)                  ivl_q <= {{(CNT_W-1){1'b0}}, tick};
      else if (tick && ivl_q != '1) ivl_q <= ivl_q + 1'b1;
      if (fin_ok || fin_err)             lng_q <= '0;
      else if (tick && lng_q != FRAME_LIM) lng_q <= lng_q + 1'b1;
      if (cap) begin
        ref_samp_q <= ivl_x + half_x;
        ref_edge_q <= half_x + (ivl_x << 1);
      end
      if (arm)   left_q <= BC_W'(NBITS);
      if (step)  left_q <= left_q - 1'b1;
      if (shift) sr_q <= {sr_q[NBITS-2:0], level};
      out_valid <= fin_ok;
      out_error <= fin_err;
      if (fin_ok) begin
        out_toggle <= sr_q[NBITS-1];
        out_addr   <= sr_q[NBITS-2 -: IR_ADDR_W];
        out_cmd    <= sr_q[IR_CMD_W-1:0];
      end else if (fin_err) begin
        out_toggle <= 1'b1;
        out_addr   <= '1;
        out_cmd    <= '1;
      end
    end
  end
endmodule

// File: rtl/ir_biphase_rx.sv
`timescale 1ns/1ps
module ir_biphase_rx
  import ir_rx_pkg::*;
#(
  parameter int TICK_DIV   = 3200,
  parameter int IDLE_TICKS = 55,
  parameter int HALF_MAX   = 17,
  parameter int FRAME_TO   = 2048,
  parameter int CNT_W      = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ir_n,
  output logic                 frame_valid,
  output logic                 frame_error,
  output logic                 frame_toggle,
  output logic [IR_ADDR_W-1:0] frame_addr,
  output logic [IR_CMD_W-1:0]  frame_cmd
);
  logic tick_w, lvl_w, rise_w, fall_w;

  ir_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick_w)
  );

  ir_line_sync u_sync (
    .clk(clk), .rst_n(rst_n), .line_in(ir_n),
    .level(lvl_w), .rise(rise_w), .fall(fall_w)
  );

  ir_frame_fsm #(
    .IDLE_TICKS(IDLE_TICKS), .HALF_MAX(HALF_MAX),
    .FRAME_TO(FRAME_TO), .CNT_W(CNT_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(tick_w),
    .level(lvl_w), .rise(rise_w), .fall(fall_w),
    .out_valid(frame_valid), .out_error(frame_error),
    .out_toggle(frame_toggle), .out_addr(frame_addr), .out_cmd(frame_cmd)
  );
endmodule

// File: rtl/ir_biphase_rx_chk.sv
`timescale 1ns/1ps
module ir_biphase_rx_chk #(
  parameter int TICK_DIV = 3200
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       frame_valid,
  input logic       frame_error,
  input logic       frame_toggle,
  input logic [4:0] frame_addr,
  input logic [5:0] frame_cmd
);
  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_valid && frame_error));

  assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

  assert_error_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_error |=> !frame_error);

  assert_error_ones_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_error |-> (frame_addr == 5'h1F && frame_cmd == 6'h3F && frame_toggle));

  assert_fields_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({frame_toggle, frame_addr, frame_cmd}) |-> (frame_valid || frame_error));

  generate
    if (TICK_DIV > 1) begin : g_tick
      assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

bind ir_biphase_rx ir_biphase_rx_chk #(.TICK_DIV(TICK_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick_w),
  .frame_valid(frame_valid), .frame_error(frame_error),
  .frame_toggle(frame_toggle), .frame_addr(frame_addr), .frame_cmd(frame_cmd)
);

// File: tb/ir_biphase_rx_tb.sv
`timescale 1ns/1ps
module ir_biphase_rx_tb;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ir_n = 1'b1;
  logic frame_valid, frame_error, frame_toggle;
  logic [4:0] frame_addr;
  logic [5:0] frame_cmd;

  int checks = 0;
  int errors = 0;
  int nval = 0;
  int nerr = 0;
  int sent = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ir_biphase_rx #(.TICK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .ir_n(ir_n),
    .frame_valid(frame_valid), .frame_error(frame_error),
    .frame_toggle(frame_toggle), .frame_addr(frame_addr), .frame_cmd(frame_cmd)
  );

  always @(negedge clk) if (rst_n) begin
    if (frame_valid) nval++;
    if (frame_error) nerr++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic lv, input int ticks);
    ir_n = lv;
    repeat (ticks * DIV) @(negedge clk);
  endtask

  // drives one frame; with chk_on the valid strobe and fields are checked
  task automatic send_frame(input int h, input logic [11:0] code,
                            input int idle, input bit chk_on);
    if (idle > 0) hold(1'b1, idle);
    hold(1'b0, h); hold(1'b1, h); hold(1'b0, h);
    for (int i = 11; i >= 0; i--) begin
      hold(code[i], h);
      if (i == 0 && chk_on) begin
        ir_n = ~code[0];
        repeat (3) @(posedge clk);
        #1;
        chk(frame_valid === 1'b1, "R10 valid three edges after last edge", int'(frame_valid), 1);
        chk(frame_toggle === code[11], "R7 toggle", int'(frame_toggle), int'(code[11]));
        chk(frame_addr === code[10:6], "R7 address", int'(frame_addr), int'(code[10:6]));
        chk(frame_cmd === code[5:0], "R11 command at this width", int'(frame_cmd), int'(code[5:0]));
        @(posedge clk); #1;
        chk(frame_valid === 1'b0, "R10 valid one cycle", int'(frame_valid), 0);
        @(negedge clk);
        repeat (h * DIV - 4) @(negedge clk);
        sent++;
      end else begin
        hold(~code[i], h);
      end
    end
  endtask

  // waits for an error strobe, returns the cycles until it appeared
  task automatic wait_err(input int max_cyc, output int cyc);
    cyc = -1;
    for (int k = 1; k <= max_cyc; k++) begin
      @(negedge clk);
      if (frame_error) begin cyc = k; break; end
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int c, v0, e0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(frame_valid === 0 && frame_error === 0, "R1 strobes low", int'({frame_valid, frame_error}), 0);
    chk({frame_toggle, frame_addr, frame_cmd} === 12'h000, "R1 fields zero",
        int'({frame_toggle, frame_addr, frame_cmd}), 0);

    // R11 sweep over half-bit widths with codes derived arithmetically
    for (int h = 4; h <= 16; h++) begin
      send_frame(h, 12'((h * 773 + 291) & 12'hFFF), 64, 1'b1);
      send_frame(h, (h % 2 == 0) ? 12'hFFF : 12'h000, 64, 1'b1);
      send_frame(h, 12'(((h * 2477) ^ 12'hA5C) & 12'hFFF), 64, 1'b1);
    end
    chk(nval == sent, "R7 one valid per frame", nval, sent);
    chk(nerr == 0, "R9 no error on good frames", nerr, 0);

    // R5: start pulse far too long
    hold(1'b1, 64);
    ir_n = 1'b0;
    wait_err(25 * DIV, c);
    chk(c >= 16 * DIV && c <= 19 * DIV, "R5 long start pulse error time", c, 17 * DIV);
    chk(frame_addr === 5'h1F && frame_cmd === 6'h3F && frame_toggle === 1'b1,
        "R9 error fields all ones", int'({frame_toggle, frame_addr, frame_cmd}), 12'hFFF);
    hold(1'b1, 10);

    // R6: second start bit never falls (h=8, ref 12 ticks)
    hold(1'b1, 64);
    hold(1'b0, 8);
    ir_n = 1'b1;
    wait_err(20 * DIV, c);
    chk(c >= 11 * DIV && c <= 14 * DIV, "R6 gap too long error time", c, 12 * DIV);

    // R8: no mid-bit edge after a sampled 0 (h=8, limit 20 ticks)
    hold(1'b1, 64);
    hold(1'b0, 8); hold(1'b1, 8);
    ir_n = 1'b0;
    wait_err(30 * DIV, c);
    chk(c >= 19 * DIV && c <= 22 * DIV, "R8 missing edge error time", c, 20 * DIV);
    hold(1'b1, 10);

    // R3: frame after a too short quiet stretch gives no strobe
    send_frame(8, 12'h3C5, 64, 1'b1);
    v0 = nval; e0 = nerr;
    hold(1'b0, 10); hold(1'b1, 20);
    send_frame(8, 12'h5A5, 0, 1'b0);
    hold(1'b1, 30);
    chk(nval == v0, "R3 no valid after short quiet", nval, v0);
    chk(nerr == e0, "R3 no error after short quiet", nerr, e0);
    chk(frame_cmd === 6'h05 && frame_addr === 5'h0F, "R3 fields untouched",
        int'({frame_addr, frame_cmd}), int'({5'h0F, 6'h05}));
    send_frame(8, 12'h9E1, 64, 1'b1);

    // R4: line held low from reset, timeout after FRAME_TO ticks
    @(negedge clk);
    rst_n = 1'b0; ir_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wait_err(9000, c);
    chk(c >= 2047 * DIV && c <= 2050 * DIV, "R4 frame timeout error time", c, 2048 * DIV);
    chk(frame_valid === 1'b0, "R2 tick based timeout without valid", int'(frame_valid), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule